// File: doc/BRIEF.md
# Decode-Stage Interlock and Short-Path Selector

This block sits beside the decode stage of a five-stage in-order integer pipeline whose stages are fetch, decode, execute (first multiply step), memory access (second multiply step) and write-back. In every cycle it compares the source register numbers that decode is about to read with the destination registers of the two older instructions in execute and in memory/second-multiply. From that comparison it chooses where each operand comes from: the register file, the execute-stage result, or the memory/second-multiply result.

A load delivers its data only at the end of the memory stage, and a multiply delivers its product only at the end of its second step. When the instruction right behind such a producer needs its result, the block holds fetch and decode for one cycle and puts an empty slot into execute. In the following cycle the producer has moved one stage on, and its late result is steered straight into decode over the short path. A dependent instruction therefore loses exactly one cycle, and a consumer two or more instructions behind loses none. A result that has already reached write-back is seen through the register file's write-through, so the block takes no write-back inputs.

All outputs are combinational functions of the present stage inputs. The clock and reset only qualify the built-in checks.

Top module: `ilk_unit`

## Requirements
- R1: When a valid instruction in execute is a load or a multiply, writes a nonzero register, and that register matches a used source of a valid decode instruction, `fetch_hold`, `decode_hold` and `ex_bubble` are all 1 in the same cycle.
- R2: With no such late match, and in particular when decode is not valid, all three hold/bubble outputs are 0.
- R3: A source that names register 0 never causes a hold and its select is always 0 (register file), even when an older stage names register 0 as its destination.
- R4: A source whose use flag is 0 never causes a hold and its select is 0.
- R5: A used nonzero source that matches a valid, writing execute instruction that is neither a load nor a multiply gets select 1 (execute result) with no hold.
- R6: A used nonzero source that matches a valid, writing instruction in memory/second-multiply, of any class, gets select 2 (memory-stage result) with no hold, unless execute also matches.
- R7: When execute and memory/second-multiply both write the matching register, the execute stage, as the younger producer, decides: select 1, or a hold if it is a load or multiply.
- R8: In a hold cycle both selects are 0.
- R9: An execute or memory-stage instruction whose valid or write-enable flag is 0 is ignored for holds and selects.
- R10: Run as a pipeline, a load or multiply immediately followed by a consumer of its result costs exactly one hold cycle, after which the consumer gets select 2. A consumer two instructions behind costs no hold cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the built-in checks |
| rst_n | input | 1 | Asynchronous active-low reset, gates the checks |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs1 | input | REG_W | First source register number in decode |
| id_rs2 | input | REG_W | Second source register number in decode |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_rd | input | REG_W | Destination register of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_is_mul | input | 1 | Execute instruction is a multiply (first step) |
| mem_valid | input | 1 | Memory/second-multiply stage holds a real instruction |
| mem_rd | input | REG_W | Destination register of that instruction |
| mem_wen | input | 1 | That instruction writes a register |
| fetch_hold | output | 1 | Keep the fetch stage contents this cycle |
| decode_hold | output | 1 | Keep the decode stage contents this cycle |
| ex_bubble | output | 1 | Load an empty slot into execute this cycle |
| rs1_sel | output | 2 | First operand source: 0 register file, 1 execute, 2 memory stage |
| rs2_sel | output | 2 | Second operand source, same encoding |

## Verification
Every output is due in the same cycle as the stage inputs that cause it: no register lies between them. The bench therefore drives the inputs just after a falling edge and compares all five outputs against its reference model one time unit later, well before the next rising edge. In the pipeline runs the bench advances its own stage model at the rising edge using the expected hold, so the one-cycle penalty of R10 appears as exactly one extra held cycle, counted from the observed `fetch_hold`.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  // Older stages that can forward into decode, youngest first:
  // index 0 = execute (first multiply step), index 1 = memory (second multiply step)
  localparam int ILK_STAGES = 2;
  localparam int SEL_W      = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_RF  = 2'd0,
    SEL_EX  = 2'd1,
    SEL_MEM = 2'd2
  } byp_sel_e;

endpackage

// File: rtl/ilk_stage_qual.sv
module ilk_stage_qual #(
  parameter int REG_W = 5
) (
  input  logic             stg_valid,
  input  logic             stg_wen,
  input  logic [REG_W-1:0] stg_rd,
  output logic             stg_live
);

  // A stage only counts as a producer when it is real, writes, and does
  // not target the hardwired zero register.
  always_comb begin
    stg_live = stg_valid & stg_wen & (stg_rd != '0);
  end

endmodule

// File: rtl/ilk_src_resolve.sv
module ilk_src_resolve
  import ilk_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int STAGES = ILK_STAGES
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          dec_valid,
  input  logic                          src_used,
  input  logic [REG_W-1:0]              src,
  input  logic [STAGES-1:0]             prod_live,
  input  logic [STAGES-1:0][REG_W-1:0]  prod_rd,
  input  logic                          young_late,
  output byp_sel_e                      sel,
  output logic                          need_stall
);

  logic [STAGES-1:0] hit;

  always_comb begin
    for (int k = 0; k < STAGES; k++) begin
      hit[k] = dec_valid & src_used & (src != '0) & prod_live[k] & (prod_rd[k] == src);
    end
  end

  // Walk from oldest to youngest so the youngest matching producer wins.
  always_comb begin
    sel = SEL_RF;
    for (int k = STAGES - 1; k >= 0; k--) begin
      if (hit[k]) begin
        sel = byp_sel_e'(SEL_W'(k + 1));
      end
    end
    need_stall = hit[0] & young_late;
  end

  // Youngest producer decides the source when it matches.
  assert_young_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && src_used && (src != '0) && prod_live[0] && (prod_rd[0] == src))
      |-> (sel == SEL_EX));

endmodule

// File: rtl/ilk_unit.sv
module ilk_unit
  import ilk_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_valid,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic             id_use_rs1,
  input  logic             id_use_rs2,
  input  logic             ex_valid,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_wen,
  input  logic             ex_is_load,
  input  logic             ex_is_mul,
  input  logic             mem_valid,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_wen,
  output logic             fetch_hold,
  output logic             decode_hold,
  output logic             ex_bubble,
  output logic [SEL_W-1:0] rs1_sel,
  output logic [SEL_W-1:0] rs2_sel
);

  localparam int NUM_SRC = 2;

  logic [ILK_STAGES-1:0]             stg_valid;
  logic [ILK_STAGES-1:0]             stg_wen;
  logic [ILK_STAGES-1:0][REG_W-1:0]  stg_rd;
  logic [ILK_STAGES-1:0]             stg_live;
  logic [NUM_SRC-1:0][REG_W-1:0]     src_num;
  logic [NUM_SRC-1:0]                src_use;
  byp_sel_e                          src_sel [NUM_SRC];
  logic [NUM_SRC-1:0]                src_stall;
  logic                              ex_late;
  logic                              stall;

  always_comb begin
    stg_valid = {mem_valid, ex_valid};
    stg_wen   = {mem_wen,   ex_wen};
    stg_rd    = {mem_rd,    ex_rd};
    src_num   = {id_rs2,    id_rs1};
    src_use   = {id_use_rs2, id_use_rs1};
    ex_late   = ex_is_load | ex_is_mul;
  end

  for (genvar g = 0; g < ILK_STAGES; g++) begin : g_stage
    ilk_stage_qual #(.REG_W(REG_W)) u_qual (
      .stg_valid (stg_valid[g]),
      .stg_wen   (stg_wen[g]),
      .stg_rd    (stg_rd[g]),
      .stg_live  (stg_live[g])
    );
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    ilk_src_resolve #(.REG_W(REG_W), .STAGES(ILK_STAGES)) u_res (
      .clk        (clk),
      .rst_n      (rst_n),
      .dec_valid  (id_valid),
      .src_used   (src_use[s]),
      .src        (src_num[s]),
      .prod_live  (stg_live),
      .prod_rd    (stg_rd),
      .young_late (ex_late),
      .sel        (src_sel[s]),
      .need_stall (src_stall[s])
    );
  end

  always_comb begin
    stall       = |src_stall;
    fetch_hold  = stall;
    decode_hold = stall;
    ex_bubble   = stall;
    rs1_sel     = stall ? SEL_RF : src_sel[0];
    rs2_sel     = stall ? SEL_RF : src_sel[1];
  end

  // A hold is only ever caused by a late producer in execute.
  assert_hold_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    decode_hold |-> (id_valid && ex_valid && ex_wen && (ex_is_load || ex_is_mul) && (ex_rd != '0)));

  assert_hold_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ex_bubble |-> ((rs1_sel == SEL_RF) && (rs2_sel == SEL_RF)));

  assert_zero_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs1 == '0) |-> (rs1_sel == SEL_RF));

  assert_unused_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_use_rs1 && !id_use_rs2) |-> (!fetch_hold && (rs1_sel == SEL_RF) && (rs2_sel == SEL_RF)));

  assert_mem_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rs2_sel == SEL_MEM) |-> (mem_valid && mem_wen && (mem_rd == id_rs2)));

endmodule

// File: tb/ilk_unit_test.sv
module ilk_unit_test;

  localparam int RW = 5;

  typedef struct packed {
    logic          v;
    logic [RW-1:0] rd;
    logic [RW-1:0] rs1;
    logic [RW-1:0] rs2;
    logic          u1;
    logic          u2;
    logic          wen;
    logic          ld;
    logic          mul;
  } ins_t;

  logic clk = 1'b0;
  logic rst_n;
  logic id_valid, id_use_rs1, id_use_rs2;
  logic [RW-1:0] id_rs1, id_rs2, ex_rd, mem_rd;
  logic ex_valid, ex_wen, ex_is_load, ex_is_mul, mem_valid, mem_wen;
  logic fetch_hold, decode_hold, ex_bubble;
  logic [1:0] rs1_sel, rs2_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ilk_unit #(.REG_W(RW)) uut (
    .clk(clk), .rst_n(rst_n),
    .id_valid(id_valid), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
    .ex_valid(ex_valid), .ex_rd(ex_rd), .ex_wen(ex_wen),
    .ex_is_load(ex_is_load), .ex_is_mul(ex_is_mul),
    .mem_valid(mem_valid), .mem_rd(mem_rd), .mem_wen(mem_wen),
    .fetch_hold(fetch_hold), .decode_hold(decode_hold), .ex_bubble(ex_bubble),
    .rs1_sel(rs1_sel), .rs2_sel(rs2_sel)
  );

  // Reference: scan older stages youngest first; first writer found decides.
  function automatic logic [2:0] ref_src(logic used, logic [RW-1:0] rs);
    logic          wr [2];
    logic [RW-1:0] dst [2];
    wr[0] = ex_valid && ex_wen;   dst[0] = ex_rd;
    wr[1] = mem_valid && mem_wen; dst[1] = mem_rd;
    if (!id_valid || !used || rs == 0) return 3'b000;
    for (int k = 0; k < 2; k++) begin
      if (wr[k] && dst[k] == rs) begin
        return {(k == 0) && (ex_is_load || ex_is_mul), 2'(k + 1)};
      end
    end
    return 3'b000;
  endfunction

  function automatic logic ref_stall();
    logic [2:0] a, b;
    a = ref_src(id_use_rs1, id_rs1);
    b = ref_src(id_use_rs2, id_rs2);
    return a[2] | b[2];
  endfunction

  task automatic check_now(string tag);
    logic [2:0] a, b;
    logic st;
    logic [1:0] e1, e2;
    a = ref_src(id_use_rs1, id_rs1);
    b = ref_src(id_use_rs2, id_rs2);
    st = a[2] | b[2];
    e1 = st ? 2'd0 : a[1:0];
    e2 = st ? 2'd0 : b[1:0];
    n_chk++;
    if (fetch_hold !== st || decode_hold !== st || ex_bubble !== st ||
        rs1_sel !== e1 || rs2_sel !== e2) begin
      n_fail++;
      $display("FAIL %s: actual hold=%b%b%b sel=%0d/%0d expected hold=%b%b%b sel=%0d/%0d",
               tag, fetch_hold, decode_hold, ex_bubble, rs1_sel, rs2_sel,
               st, st, st, e1, e2);
    end
  endtask

  task automatic check_val(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    id_valid = 0; id_rs1 = 0; id_rs2 = 0; id_use_rs1 = 0; id_use_rs2 = 0;
    ex_valid = 0; ex_rd = 0; ex_wen = 0; ex_is_load = 0; ex_is_mul = 0;
    mem_valid = 0; mem_rd = 0; mem_wen = 0;
  endtask

  task automatic set_id(logic [RW-1:0] r1, logic u1, logic [RW-1:0] r2, logic u2);
    id_valid = 1; id_rs1 = r1; id_use_rs1 = u1; id_rs2 = r2; id_use_rs2 = u2;
  endtask

  task automatic set_ex(logic v, logic [RW-1:0] rd, logic w, logic ld, logic mu);
    ex_valid = v; ex_rd = rd; ex_wen = w; ex_is_load = ld; ex_is_mul = mu;
  endtask

  task automatic set_mem(logic v, logic [RW-1:0] rd, logic w);
    mem_valid = v; mem_rd = rd; mem_wen = w;
  endtask

  // Directed vector: drive after the falling edge, compare 1 time unit later.
  task automatic vec(string tag, int exp_hold, int exp1, int exp2);
    #1;
    check_now(tag);
    check_val({tag, " hold"}, int'(decode_hold), exp_hold);
    check_val({tag, " rs1_sel"}, int'(rs1_sel), exp1);
    check_val({tag, " rs2_sel"}, int'(rs2_sel), exp2);
    @(negedge clk);
    clear_in();
  endtask

  function automatic ins_t mk(int rd, int r1, int r2, bit u1, bit u2, bit w, bit ld, bit mu);
    ins_t i;
    i.v = 1; i.rd = RW'(rd); i.rs1 = RW'(r1); i.rs2 = RW'(r2);
    i.u1 = u1; i.u2 = u2; i.wen = w; i.ld = ld; i.mul = mu;
    return i;
  endfunction

  // Closed-loop pipeline run, stages advanced from the reference hold decision.
  task automatic run_prog(string tag, ins_t prog[$], int exp_holds);
    ins_t s_id, s_ex, s_mem;
    int pc = 0;
    int holds = 0;
    int guard = 0;
    logic st;
    s_id = '0; s_ex = '0; s_mem = '0;
    while ((pc < prog.size() || s_id.v || s_ex.v || s_mem.v) && guard < 64) begin
      guard++;
      @(negedge clk);
      id_valid = s_id.v; id_rs1 = s_id.rs1; id_rs2 = s_id.rs2;
      id_use_rs1 = s_id.u1; id_use_rs2 = s_id.u2;
      set_ex(s_ex.v, s_ex.rd, s_ex.wen, s_ex.ld, s_ex.mul);
      set_mem(s_mem.v, s_mem.rd, s_mem.wen);
      #1;
      check_now({tag, " cycle"});
      if (fetch_hold === 1'b1) holds++;
      st = ref_stall();
      @(posedge clk);
      s_mem = s_ex;
      if (st) begin
        s_ex = '0;
      end else begin
        s_ex = s_id;
        if (pc < prog.size()) begin
          s_id = prog[pc];
          pc++;
        end else begin
          s_id = '0;
        end
      end
    end
    check_val({tag, " hold cycles"}, holds, exp_holds);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    ins_t p[$];
    clear_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R2: quiet state around reset
    #1;
    check_now("R2 reset");
    check_val("R2 reset hold", int'(fetch_hold), 0);
    rst_n = 1;
    @(negedge clk);

    // R1: load in execute feeding rs1
    set_id(5'd6, 1, 5'd0, 0); set_ex(1, 5'd6, 1, 1, 0); vec("R1 load", 1, 0, 0);
    // R1: multiply in execute feeding rs2
    set_id(5'd0, 0, 5'd9, 1); set_ex(1, 5'd9, 1, 0, 1); vec("R1 mul", 1, 0, 0);
    // R2: decode not valid
    set_ex(1, 5'd6, 1, 1, 0); id_rs1 = 5'd6; id_use_rs1 = 1; vec("R2 idle decode", 0, 0, 0);
    // R3: register zero on both sides
    set_id(5'd0, 1, 5'd0, 1); set_ex(1, 5'd0, 1, 1, 0); set_mem(1, 5'd0, 1); vec("R3 zero", 0, 0, 0);
    // R4: matching but unused sources
    set_id(5'd5, 0, 5'd5, 0); set_ex(1, 5'd5, 1, 1, 0); vec("R4 unused", 0, 0, 0);
    // R5: plain ALU result in execute
    set_id(5'd3, 1, 5'd4, 1); set_ex(1, 5'd4, 1, 0, 0); vec("R5 alu", 0, 0, 1);
    // R6: multiply product in second step
    set_id(5'd2, 1, 5'd7, 1); set_mem(1, 5'd7, 1); vec("R6 mem", 0, 0, 2);
    // R7: both stages write the register, execute wins
    set_id(5'd3, 1, 5'd3, 1); set_ex(1, 5'd3, 1, 0, 0); set_mem(1, 5'd3, 1); vec("R7 young", 0, 1, 1);
    // R7 + R8: late younger producer over an older one, hold forces selects to 0
    set_id(5'd4, 1, 5'd8, 1); set_ex(1, 5'd4, 1, 1, 0); set_mem(1, 5'd8, 1); vec("R8 hold sel", 1, 0, 0);
    // R9: non-writing / invalid stages ignored
    set_id(5'd2, 1, 5'd2, 1); set_ex(1, 5'd2, 0, 1, 0); set_mem(0, 5'd2, 1); vec("R9 ignored", 0, 0, 0);
    set_id(5'd2, 1, 5'd1, 1); set_ex(0, 5'd2, 1, 1, 0); set_mem(1, 5'd1, 0); vec("R9 invalid", 0, 0, 0);

    // R10: pipeline sequences
    p = '{mk(6, 4, 0, 1, 0, 1, 1, 0), mk(6, 6, 0, 1, 0, 1, 0, 0), mk(1, 0, 0, 0, 0, 1, 0, 0)};
    run_prog("R10 load-use", p, 1);
    p = '{mk(6, 4, 0, 1, 0, 1, 1, 0), mk(1, 2, 0, 1, 0, 1, 0, 0), mk(7, 0, 6, 0, 1, 1, 0, 0)};
    run_prog("R10 load-gap", p, 0);
    p = '{mk(6, 6, 0, 1, 0, 1, 0, 1), mk(6, 0, 6, 0, 1, 1, 0, 0)};
    run_prog("R10 mul-use", p, 1);
    p = '{mk(0, 4, 0, 1, 0, 1, 1, 0), mk(3, 0, 0, 1, 1, 1, 0, 0)};
    run_prog("R10 zero-dest", p, 0);
    p = '{mk(5, 1, 0, 1, 0, 1, 1, 0), mk(5, 5, 0, 1, 0, 1, 1, 0), mk(2, 5, 5, 1, 1, 1, 0, 0)};
    run_prog("R10 chain", p, 2);

    // Random sweep over a small register range, compared every cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      id_valid = 1'($urandom_range(0, 3) != 0);
      id_rs1 = RW'($urandom_range(0, 3)); id_rs2 = RW'($urandom_range(0, 3));
      id_use_rs1 = 1'($urandom); id_use_rs2 = 1'($urandom);
      ex_valid = 1'($urandom); ex_rd = RW'($urandom_range(0, 3)); ex_wen = 1'($urandom_range(0, 3) != 0);
      ex_is_load = 1'($urandom); ex_is_mul = 1'($urandom_range(0, 3) == 0);
      mem_valid = 1'($urandom); mem_rd = RW'($urandom_range(0, 3)); mem_wen = 1'($urandom);
      #1;
      if (ref_stall()) check_now("R1 random");
      else check_now("R5 R6 R7 random");
    end

    @(negedge clk);
    finish_run();
  end

endmodule